// File: doc/BRIEF.md
# Two-Operand Instruction Bus-Cycle Sequencer

This block sequences the bus traffic of a small 16-bit processor whose code and data share one memory. It fetches an instruction word at the program counter, works out the source and destination addressing modes, and then issues at most one memory transaction per clock. The possible transactions are an extension-word read, an operand read, a destination read or a write-back. It holds sixteen 16-bit registers. Register 0 is the program counter, register 2 is the status register and register 3 supplies constants. It executes a word-sized move and a PC-relative jump. No other operations are implemented.

Every cycle that the instruction costs is a bus cycle. The only exceptions are the second clock of a jump and the extra clock taken when a move targets the program counter. When an instruction retires, a one-clock done pulse carries its cycle count. That pulse coincides with the fetch of the following instruction. Memory is synchronous: read data appears in the clock after the address.

Top module: `twoop_bus_seq`

## Requirements
- R1: After reset, the first clock issues a read at address 0 with write enable low. Every fetch reads the word at the PC, and the PC then advances by 2.
- R2: A move whose source and destination are both registers (source mode 00, destination bit 0) takes 1 cycle. The destination register holds the value in time for the next instruction.
- R3: Source mode 01 reads an offset word and then the data at base+offset, for 3 cycles into a register. With base register 2 the base is zero (absolute). With base register 0 the base is the address of the offset word (symbolic).
- R4: Source register 0 in mode 11 is an immediate operand: one read of the word after the instruction, for 2 cycles into a register.
- R5: Register 3 in modes 00/01/10/11 yields 0, 1, 2 and 0xFFFF. Register 2 in modes 10/11 yields 4 and 8. None of these costs a bus cycle.
- R6: Mode 10 reads at the register's address. Mode 11 does the same and also adds 2 to the register, at no extra cycle cost: an autoincrement source into an indexed destination takes 5 cycles.
- R7: An indexed destination (destination bit 1) reads its offset word, then reads the destination address, then writes that same address in the next clock. Register to absolute takes 4 cycles; indexed to indexed takes 6.
- R8: A move into register 0 takes one extra cycle, and the loaded PC has bit 0 cleared.
- R9: A jump (bits 15:13 = 001, condition in bits 12:10, signed word offset in bits 9:0) always takes 2 cycles. When taken, the target is the jump address + 2 + 2*offset. Condition 000 is taken when status bit 1 is clear, 001 when it is set, 111 always; every other condition is never taken.
- R10: done pulses for one clock per retired instruction, and doneCycles gives that instruction's cycle count. Read and write are never issued in the same clock.
- R11: The move is bits 15:12 = 0100 with bit 6 = 0. Its source register is in bits 11:8, its destination bit is bit 7, its source mode is in bits 5:4 and its destination register is in bits 3:0. Any other word is a 1-cycle no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memAddr | output | 16 | Byte address of the current transaction |
| memRd | output | 1 | Read issued this clock |
| memWe | output | 1 | Write issued this clock |
| memWData | output | 16 | Write data |
| memRData | input | 16 | Data for the read issued in the previous clock |
| done | output | 1 | An instruction retires this clock |
| doneCycles | output | 4 | Cycle count of the retiring instruction |

## Verification
The clock in which an instruction retires is also the clock that fetches the next instruction. In that clock the destination register is written from the returning read data while the PC is both read and advanced. This overlap is provoked by a chain of instructions: an immediate load into R4 is followed at once by a register copy of R4, and the copy is stored to memory. Any slip shows up as a wrong stored value or a wrong cycle count. Each memory write is also checked against the read of the same address in the clock before it.

// File: rtl/twoop_pkg.sv
package twoop_pkg;

  localparam int WORD_W = 16;
  localparam int REG_W  = 4;

  typedef enum logic [3:0] {
    OP_FETCH, OP_DECIDE, OP_SRCEXT, OP_SRCRD, OP_DSTEXT,
    OP_DSTRD, OP_WRITE, OP_PCX, OP_JMP
  } busOpT;

  typedef struct packed {
    busOpT op;
    busOpT prev;
    logic  decide;
    logic  retire;
  } strobeT;

  typedef struct packed {
    logic             isMov;
    logic             isJmp;
    logic [REG_W-1:0] srcReg;
    logic [1:0]       srcMode;
    logic             dstMem;
    logic [REG_W-1:0] dstReg;
    logic             srcConst;
    logic             srcIdx;
    logic             srcMem;
    logic [2:0]       cond;
    logic [9:0]       jOff;
  } decT;

  localparam logic [1:0] AM_REG = 2'b00;
  localparam logic [1:0] AM_IDX = 2'b01;
  localparam logic [1:0] AM_IND = 2'b10;
  localparam logic [1:0] AM_INC = 2'b11;

  function automatic decT decodeWord(logic [WORD_W-1:0] w);
    decT d;
    d.isMov    = (w[15:12] == 4'b0100) && !w[6];
    d.isJmp    = (w[15:13] == 3'b001);
    d.srcReg   = w[11:8];
    d.dstMem   = w[7];
    d.srcMode  = w[5:4];
    d.dstReg   = w[3:0];
    d.srcConst = (w[11:8] == 4'd3) || ((w[11:8] == 4'd2) && w[5]);
    d.srcIdx   = (w[5:4] == AM_IDX) && !d.srcConst;
    d.srcMem   = (w[5:4] != AM_REG) && !d.srcConst;
    d.cond     = w[12:10];
    d.jOff     = w[9:0];
    return d;
  endfunction

endpackage

// File: rtl/twoop_ctrl.sv
module twoop_ctrl
  import twoop_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  decT              dec,
  output strobeT           stb,
  output logic [CNT_W-1:0] cycles
);

  busOpT phase, prevOp, op, nxt;
  logic  inFlight;
  logic [CNT_W-1:0] cnt;

  // What follows once the source operand is in hand
  function automatic busOpT afterSrc(decT d);
    if (d.isMov && d.dstMem)              return OP_DSTEXT;
    else if (d.isMov && d.dstReg == 4'd0) return OP_PCX;
    else                                  return OP_FETCH;
  endfunction

  function automatic busOpT firstOp(decT d);
    if (d.isJmp)                   return OP_JMP;
    else if (d.isMov && d.srcIdx)  return OP_SRCEXT;
    else if (d.isMov && d.srcMem)  return OP_SRCRD;
    else                           return afterSrc(d);
  endfunction

  always_comb begin
    op = (phase == OP_DECIDE) ? firstOp(dec) : phase;
    case (op)
      OP_FETCH:  nxt = OP_DECIDE;
      OP_SRCEXT: nxt = OP_SRCRD;
      OP_SRCRD:  nxt = afterSrc(dec);
      OP_DSTEXT: nxt = OP_DSTRD;
      OP_DSTRD:  nxt = OP_WRITE;
      default:   nxt = OP_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= OP_FETCH;
      prevOp   <= OP_PCX;
      inFlight <= 1'b0;
      cnt      <= '0;
    end else begin
      phase  <= nxt;
      prevOp <= op;
      if (op == OP_FETCH) begin
        inFlight <= 1'b1;
        cnt      <= CNT_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  assign stb.op     = op;
  assign stb.prev   = prevOp;
  assign stb.decide = (phase == OP_DECIDE);
  assign stb.retire = (op == OP_FETCH) && inFlight;
  assign cycles     = cnt;

  // R3
  ext_then_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_SRCEXT) |=> (op == OP_SRCRD));
  // R7
  dst_rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_DSTRD) |=> (op == OP_WRITE));
  // R9
  jmp_two_cyc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_JMP) |=> (op == OP_FETCH));
  // R10
  done_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.retire |-> (cnt != '0));

endmodule

// File: rtl/twoop_dpath.sv
module twoop_dpath
  import twoop_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  output decT               dec,
  output logic [WORD_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWe,
  output logic [WORD_W-1:0] memWData,
  input  logic [WORD_W-1:0] memRData
);

  localparam int NREG = 1 << REG_W;
  localparam logic [WORD_W-1:0] STEP = WORD_W'(2);

  logic [WORD_W-1:0] rf [NREG];
  logic [WORD_W-1:0] irReg, srcHold, dstAddr;
  logic [WORD_W-1:0] pc, curInstr, cgVal, srcRead, srcNow;
  logic [WORD_W-1:0] srcBase, dstBase, jTgt;
  logic              jTaken, autoInc, immRead, regWrEn;

  assign pc       = rf[0];
  assign curInstr = stb.decide ? memRData : irReg;
  assign dec      = decodeWord(curInstr);

  // Constant generator on registers 2 and 3
  always_comb begin
    case ({dec.srcReg == 4'd2, dec.srcMode})
      3'b000:  cgVal = WORD_W'(0);
      3'b001:  cgVal = WORD_W'(1);
      3'b010:  cgVal = WORD_W'(2);
      3'b011:  cgVal = '1;
      3'b110:  cgVal = WORD_W'(4);
      3'b111:  cgVal = WORD_W'(8);
      default: cgVal = '0;
    endcase
    srcRead = dec.srcConst ? cgVal : rf[dec.srcReg];
    if (stb.prev == OP_SRCRD)  srcNow = memRData;
    else if (stb.decide)       srcNow = srcRead;
    else                       srcNow = srcHold;
  end

  // Index bases: PC base is the offset word's own address, R2/R3 give zero
  always_comb begin
    case (dec.srcReg)
      4'd0:       srcBase = pc - STEP;
      4'd2, 4'd3: srcBase = '0;
      default:    srcBase = rf[dec.srcReg];
    endcase
    case (dec.dstReg)
      4'd0:       dstBase = pc - STEP;
      4'd2, 4'd3: dstBase = '0;
      default:    dstBase = rf[dec.dstReg];
    endcase
  end

  always_comb begin
    case (dec.cond)
      3'b000:  jTaken = !rf[2][1];
      3'b001:  jTaken = rf[2][1];
      3'b111:  jTaken = 1'b1;
      default: jTaken = 1'b0;
    endcase
    jTgt = pc + {{5{dec.jOff[9]}}, dec.jOff, 1'b0};
  end

  assign immRead = (dec.srcMode == AM_INC) && (dec.srcReg == 4'd0);
  assign autoInc = (stb.op == OP_SRCRD) && (dec.srcMode == AM_INC)
                   && (dec.srcReg != 4'd0);
  assign regWrEn = stb.retire && dec.isMov && !dec.dstMem
                   && (dec.dstReg != 4'd0) && (dec.dstReg != 4'd3);

  always_comb begin
    memRd    = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memWData = srcHold;
    case (stb.op)
      OP_FETCH, OP_SRCEXT, OP_DSTEXT: begin
        memRd   = 1'b1;
        memAddr = pc;
      end
      OP_SRCRD: begin
        memRd   = 1'b1;
        memAddr = dec.srcIdx ? (srcBase + memRData) : rf[dec.srcReg];
      end
      OP_DSTRD: begin
        memRd   = 1'b1;
        memAddr = dstBase + memRData;
      end
      OP_WRITE: begin
        memWe   = 1'b1;
        memAddr = dstAddr;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      rf[0]   <= RESET_PC;
      irReg   <= '0;
      srcHold <= '0;
      dstAddr <= '0;
    end else begin
      if (stb.decide) irReg <= memRData;
      if (stb.decide || stb.prev == OP_SRCRD) srcHold <= srcNow;
      if (stb.op == OP_DSTRD) dstAddr <= memAddr;
      case (stb.op)
        OP_FETCH, OP_SRCEXT, OP_DSTEXT: rf[0] <= pc + STEP;
        OP_SRCRD: begin
          if (immRead)      rf[0] <= pc + STEP;
          else if (autoInc) rf[dec.srcReg] <= rf[dec.srcReg] + STEP;
        end
        OP_PCX: rf[0] <= {srcNow[WORD_W-1:1], 1'b0};
        OP_JMP: if (jTaken) rf[0] <= jTgt;
        default: ;
      endcase
      if (regWrEn) rf[dec.dstReg] <= srcNow;
    end
  end

  // R10
  one_txn_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRd, memWe}));
  // R1
  fetch_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.op == OP_FETCH) |=> (pc == $past(pc) + STEP));
  // R8
  pc_even_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.op == OP_PCX) |=> (pc[0] == 1'b0));
  // R7
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.op == OP_DSTRD) |=> (memWe && memAddr == $past(memAddr)));

endmodule

// File: rtl/twoop_bus_seq.sv
module twoop_bus_seq
  import twoop_pkg::*;
#(
  parameter int                CNT_W    = 4,
  parameter logic [WORD_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [WORD_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWe,
  output logic [WORD_W-1:0] memWData,
  input  logic [WORD_W-1:0] memRData,
  output logic              done,
  output logic [CNT_W-1:0]  doneCycles
);

  strobeT stb;
  decT    dec;

  twoop_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .dec    (dec),
    .stb    (stb),
    .cycles (doneCycles)
  );

  twoop_dpath #(.RESET_PC(RESET_PC)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .dec      (dec),
    .memAddr  (memAddr),
    .memRd    (memRd),
    .memWe    (memWe),
    .memWData (memWData),
    .memRData (memRData)
  );

  assign done = stb.retire;

endmodule

// File: tb/tb_twoop_bus_seq.sv
module tb_twoop_bus_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] memAddr, memWData, memRData;
  logic        memRd, memWe, done;
  logic [3:0]  doneCycles;
  logic [15:0] mem [256];
  int          nChecks = 0;
  int          nErr = 0;
  int          gotCyc [16];
  logic        prevRd = 1'b0;
  logic [15:0] prevA = '0;

  always #5 clk = ~clk;

  twoop_bus_seq dut (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRd(memRd), .memWe(memWe),
    .memWData(memWData), .memRData(memRData), .done(done), .doneCycles(doneCycles)
  );

  // Synchronous memory: read data appears one clock after the address
  always @(posedge clk) begin
    if (memWe) mem[memAddr[8:1]] <= memWData;
    memRData <= mem[memAddr[8:1]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R7: every write is preceded by a read of the same address
  always @(negedge clk) begin
    if (rstN) begin
      if (memWe) chk(prevRd && prevA == memAddr, "R7 dest read before write", prevA, memAddr);
      prevRd = memRd;
      prevA  = memAddr;
    end else begin
      prevRd = 1'b0;
    end
  end

  function automatic logic [15:0] mv(int s, int sm, int dm, int d);
    return {4'b0100, 4'(s), 1'(dm), 1'b0, 2'(sm), 4'(d)};
  endfunction

  function automatic logic [15:0] jp(int c, int off);
    return {3'b001, 3'(c), 10'(off)};
  endfunction

  task automatic clearMem();
    rstN = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
  endtask

  task automatic go();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runN(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (done) begin
        gotCyc[k] = doneCycles;
        k++;
      end
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] rd(int a);
    return mem[a >> 1];
  endfunction

  task automatic testReset();
    @(negedge clk);
    clearMem();
    go();
    #1;
    chk(memRd === 1'b1, "R1 first clock reads", memRd, 1);
    chk(memAddr === 16'h0000, "R1 first fetch address", memAddr, 0);
    chk(memWe === 1'b0, "R1 no write after reset", memWe, 0);
    chk(done === 1'b0, "R10 no done after reset", done, 0);
    @(negedge clk);
    chk(memAddr === 16'h0002, "R1 next read at PC+2", memAddr, 2);
  endtask

  task automatic testImmReg();
    @(negedge clk);
    clearMem();
    mem[0] = mv(0, 3, 0, 4); mem[1] = 16'h1234;
    mem[2] = mv(4, 0, 0, 5);
    mem[3] = mv(5, 0, 1, 2); mem[4] = 16'h0100;
    go();
    runN(3);
    chk(gotCyc[0] == 2, "R4 immediate cycles", gotCyc[0], 2);
    chk(gotCyc[1] == 1, "R2 reg-reg cycles", gotCyc[1], 1);
    chk(gotCyc[2] == 4, "R7 reg to absolute cycles", gotCyc[2], 4);
    chk(rd(16'h100) == 16'h1234, "R2 chained reg value stored", rd(16'h100), 16'h1234);
  endtask

  task automatic testConst();
    int cr [6] = '{3, 3, 3, 3, 2, 2};
    int cm [6] = '{0, 1, 2, 3, 2, 3};
    logic [15:0] cv [6] = '{16'h0000, 16'h0001, 16'h0002, 16'hFFFF, 16'h0004, 16'h0008};
    @(negedge clk);
    clearMem();
    for (int i = 0; i < 6; i++) begin
      mem[3*i]   = mv(cr[i], cm[i], 0, 6);
      mem[3*i+1] = mv(6, 0, 1, 2);
      mem[3*i+2] = 16'(16'h0100 + 2*i);
    end
    for (int i = 0; i < 6; i++) mem[128 + i] = 16'hAAAA;
    go();
    runN(12);
    for (int i = 0; i < 6; i++) begin
      chk(gotCyc[2*i] == 1, "R5 constant costs no bus cycle", gotCyc[2*i], 1);
      chk(rd(16'h100 + 2*i) == cv[i], "R5 constant value", rd(16'h100 + 2*i), cv[i]);
    end
  endtask

  task automatic testAbsSym();
    @(negedge clk);
    clearMem();
    mem[0] = mv(2, 1, 0, 4); mem[1] = 16'h0120;
    mem[2] = mv(4, 0, 1, 2); mem[3] = 16'h0140;
    mem[4] = mv(0, 1, 0, 5); mem[5] = 16'h0126;
    mem[6] = mv(5, 0, 1, 2); mem[7] = 16'h0142;
    mem[16'h120 >> 1] = 16'hBEEF;
    mem[16'h130 >> 1] = 16'h5A5A;
    go();
    runN(4);
    chk(gotCyc[0] == 3, "R3 absolute source cycles", gotCyc[0], 3);
    chk(gotCyc[2] == 3, "R3 symbolic source cycles", gotCyc[2], 3);
    chk(gotCyc[3] == 4, "R7 register to absolute cycles", gotCyc[3], 4);
    chk(rd(16'h140) == 16'hBEEF, "R3 absolute data", rd(16'h140), 16'hBEEF);
    chk(rd(16'h142) == 16'h5A5A, "R3 symbolic data", rd(16'h142), 16'h5A5A);
  endtask

  task automatic testIdxInc();
    @(negedge clk);
    clearMem();
    mem[0]  = mv(0, 3, 0, 4); mem[1]  = 16'h0150;
    mem[2]  = mv(0, 3, 0, 6); mem[3]  = 16'h0160;
    mem[4]  = mv(4, 1, 1, 4); mem[5]  = 16'h0004; mem[6] = 16'h0008;
    mem[7]  = mv(6, 3, 1, 4); mem[8]  = 16'h0002;
    mem[9]  = mv(6, 0, 1, 2); mem[10] = 16'h0144;
    mem[11] = mv(6, 2, 0, 7);
    mem[12] = mv(7, 0, 1, 2); mem[13] = 16'h0146;
    mem[16'h154 >> 1] = 16'h1111;
    mem[16'h160 >> 1] = 16'h2222;
    mem[16'h162 >> 1] = 16'h3333;
    go();
    runN(7);
    chk(gotCyc[2] == 6, "R7 indexed to indexed cycles", gotCyc[2], 6);
    chk(gotCyc[3] == 5, "R6 autoincrement to indexed cycles", gotCyc[3], 5);
    chk(gotCyc[5] == 2, "R6 indirect to register cycles", gotCyc[5], 2);
    chk(rd(16'h158) == 16'h1111, "R7 indexed destination data", rd(16'h158), 16'h1111);
    chk(rd(16'h152) == 16'h2222, "R6 autoincrement data", rd(16'h152), 16'h2222);
    chk(rd(16'h144) == 16'h0162, "R6 register advanced by 2", rd(16'h144), 16'h0162);
    chk(rd(16'h146) == 16'h3333, "R6 indirect data", rd(16'h146), 16'h3333);
  endtask

  task automatic testFlow();
    @(negedge clk);
    clearMem();
    mem[0]  = mv(0, 3, 0, 0); mem[1] = 16'h0021;
    mem[16] = jp(7, 2);
    mem[17] = mv(3, 1, 0, 9);
    mem[18] = mv(3, 1, 0, 9);
    mem[19] = mv(3, 2, 0, 2);
    mem[20] = jp(0, 1);
    mem[21] = jp(1, 1);
    mem[22] = mv(3, 1, 0, 9);
    mem[23] = mv(9, 0, 1, 2); mem[24] = 16'h0148;
    mem[25] = 16'hF000;
    mem[16'h148 >> 1] = 16'h7777;
    go();
    runN(7);
    chk(gotCyc[0] == 3, "R8 move to PC extra cycle", gotCyc[0], 3);
    chk(gotCyc[1] == 2, "R9 taken jump cycles", gotCyc[1], 2);
    chk(gotCyc[2] == 1, "R5 constant into status", gotCyc[2], 1);
    chk(gotCyc[3] == 2, "R9 untaken jump cycles", gotCyc[3], 2);
    chk(gotCyc[4] == 2, "R9 taken conditional cycles", gotCyc[4], 2);
    chk(gotCyc[5] == 4, "R9 landed on store after jumps", gotCyc[5], 4);
    chk(gotCyc[6] == 1, "R11 unknown word is 1-cycle no-op", gotCyc[6], 1);
    chk(rd(16'h148) == 16'h0000, "R8 R9 skipped code not executed", rd(16'h148), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testImmReg();
    testConst();
    testAbsSym();
    testIdxInc();
    testFlow();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule